// File: doc/BRIEF.md
# Synthetic Converter Register Block

This block is a memory-mapped register file that stands in for an analog-to-digital converter. There is no sampling hardware behind it. Software sets up control words exactly as it would for a real converter. Each qualified read of the result register then produces a new, deterministic pseudo-sample: a running accumulator that steps by a fixed amount, is truncated to the chosen resolution, and is optionally returned left-aligned.

The bus is a plain 32-bit single-cycle register port. A write commits on the clock edge where the write strobe is high. A read is accepted on the edge where the read strobe is high, and its data is registered, so it appears on the read-data output one cycle later. Beside the control words, the block keeps a set of configuration words: sample times, window thresholds, sequence words, per-channel offset and data words for the injected path, and a status word. Software can only clear bits in the status word. None of these words drive any behaviour other than what is read back.

Top module: `synth_conv_regs`

## Requirements
- R1: After reset every register reads 0, except the high-threshold word at offset 0x24, which reads 0x00000FFF. The internal accumulator also restarts at 0.
- R2: Read data is registered. The value for a read accepted at edge N is on `bus_rdata` after edge N, and it holds until the next accepted read.
- R3: A read of the result word (offset 0x4C) while control word B (0x08) has bit 0 (enable) and bit 30 (start) both set is a conversion. It adds 7 to the accumulator, truncates the sum to the selected resolution, stores the truncated value back, clears bit 30, and returns the processed value.
- R4: A read of 0x4C while bit 0 or bit 30 of control word B is clear returns 0. The accumulator and bit 30 are left unchanged.
- R5: Control word A (0x04) bits 25:24 select the resolution. A value of 0 keeps 12 bits, 1 keeps 10 bits, 2 keeps 8 bits and 3 keeps 6 bits. The accumulator wraps within the kept width.
- R6: When bit 11 of control word B is set, a conversion returns the truncated value shifted left by one and ANDed with 0xFFF0. When bit 11 is clear, it returns the truncated value itself.
- R7: A read of control word B returns its bits 27:0, with bits 31:28 read as 0. The stored start bit (bit 30) still takes part in conversions.
- R8: A write to the status word (0x00) ANDs the stored value with the low 6 bits of the write data. The status word therefore never gains a set bit.
- R9: The four injected-offset words (0x14, 0x18, 0x1C, 0x20) store only the low 12 bits of a write. A read of injected-data word n (0x3C, 0x40, 0x44, 0x48) returns the stored data word minus offset word n, modulo 2^32.
- R10: Control word A, control word B bit 1, the sample-time words (0x0C, 0x10), the thresholds (0x24, 0x28), the sequence words (0x2C, 0x30, 0x34) and the injected-sequence word (0x38) read back exactly what was written.
- R11: Reads of unmapped or unaligned offsets return 0. Writes to them have no effect. A write to the result word 0x4C is also ignored and leaves the accumulator unchanged.
- R12: Each accepted read of 0x4C causes at most one conversion. A second read on the next cycle, with no new start, returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |

## Verification
The assertions assume that the bus never raises the read and write strobes in the same cycle. They also assume that a read of the result word is never issued in the cycle that rewrites control word B. Without both assumptions, the start-bit and accumulator properties would be ambiguous. The stimulus drives every access from its own task and separates it from the next access by at least one cycle. The one exception is the back-to-back read test, which holds the read strobe with no write between the two reads. The sample values are predicted by a bench-side model of step, truncate and align, which is updated only on reads it expects to convert.

// File: rtl/sconv_pkg.sv
package sconv_pkg;
  // Byte offsets of the register words
  localparam int OFF_STAT   = 'h00;
  localparam int OFF_CTLA   = 'h04;
  localparam int OFF_CTLB   = 'h08;
  localparam int OFF_SMPA   = 'h0C;
  localparam int OFF_SMPB   = 'h10;
  localparam int OFF_IOFF0  = 'h14;
  localparam int OFF_THRHI  = 'h24;
  localparam int OFF_THRLO  = 'h28;
  localparam int OFF_SEQ0   = 'h2C;
  localparam int OFF_ISEQ   = 'h38;
  localparam int OFF_IDAT0  = 'h3C;
  localparam int OFF_RESULT = 'h4C;

  // Bit positions the behaviour depends on
  localparam int EN_BIT    = 0;
  localparam int ALIGN_BIT = 11;
  localparam int START_BIT = 30;
  localparam int RES_LSB   = 24;
  localparam int RD_KEEP   = 28;   // control B reads back bits below this
  localparam int STAT_W    = 6;
  localparam int IOFF_W    = 12;

  function automatic logic [31:0] res_mask(input logic [1:0] res);
    case (res)
      2'd0:    res_mask = 32'h0000_0FFF;
      2'd1:    res_mask = 32'h0000_03FF;
      2'd2:    res_mask = 32'h0000_00FF;
      default: res_mask = 32'h0000_003F;
    endcase
  endfunction
endpackage

// File: rtl/sconv_cfg_regs.sv
module sconv_cfg_regs
  import sconv_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int N_INJ      = 4,
  parameter int N_SEQ      = 3,
  parameter logic [31:0] THR_HI_RST = 32'h0000_0FFF
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           clr_start,
  output logic [DATA_W-1:0]              stat,
  output logic [DATA_W-1:0]              ctl_a,
  output logic [DATA_W-1:0]              ctl_b,
  output logic [DATA_W-1:0]              smp_a,
  output logic [DATA_W-1:0]              smp_b,
  output logic [DATA_W-1:0]              thr_hi,
  output logic [DATA_W-1:0]              thr_lo,
  output logic [DATA_W-1:0]              iseq,
  output logic [N_SEQ-1:0][DATA_W-1:0]   seq,
  output logic [N_INJ-1:0][DATA_W-1:0]   ioff,
  output logic [N_INJ-1:0][DATA_W-1:0]   idat
);
  localparam logic [DATA_W-1:0] STAT_KEEP = DATA_W'((1 << STAT_W) - 1);
  localparam logic [DATA_W-1:0] IOFF_KEEP = DATA_W'((1 << IOFF_W) - 1);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    hit = (a == ADDR_W'(off));
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      stat   <= '0;
      ctl_a  <= '0;
      ctl_b  <= '0;
      smp_a  <= '0;
      smp_b  <= '0;
      thr_hi <= DATA_W'(THR_HI_RST);
      thr_lo <= '0;
      iseq   <= '0;
    end else begin
      if (wr_en && hit(wr_addr, OFF_STAT))  stat   <= stat & (wr_data & STAT_KEEP);
      if (wr_en && hit(wr_addr, OFF_CTLA))  ctl_a  <= wr_data;
      if (wr_en && hit(wr_addr, OFF_SMPA))  smp_a  <= wr_data;
      if (wr_en && hit(wr_addr, OFF_SMPB))  smp_b  <= wr_data;
      if (wr_en && hit(wr_addr, OFF_THRHI)) thr_hi <= wr_data;
      if (wr_en && hit(wr_addr, OFF_THRLO)) thr_lo <= wr_data;
      if (wr_en && hit(wr_addr, OFF_ISEQ))  iseq   <= wr_data;
      if (wr_en && hit(wr_addr, OFF_CTLB))  ctl_b  <= wr_data;
      else if (clr_start)                   ctl_b[START_BIT] <= 1'b0;
    end
  end

  for (genvar s = 0; s < N_SEQ; s++) begin : g_seq
    always_ff @(posedge clk) begin
      if (rst)                                   seq[s] <= '0;
      else if (wr_en && hit(wr_addr, OFF_SEQ0 + 4*s)) seq[s] <= wr_data;
    end
  end

  for (genvar n = 0; n < N_INJ; n++) begin : g_inj
    always_ff @(posedge clk) begin
      if (rst) begin
        ioff[n] <= '0;
        idat[n] <= '0;
      end else begin
        if (wr_en && hit(wr_addr, OFF_IOFF0 + 4*n)) ioff[n] <= wr_data & IOFF_KEEP;
        if (wr_en && hit(wr_addr, OFF_IDAT0 + 4*n)) idat[n] <= wr_data;
      end
    end

    AST_IOFF_NARROW: assert property (@(posedge clk) disable iff (rst)
      (ioff[n] & ~IOFF_KEEP) == '0);                                   // R9
  end

  AST_STAT_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit(wr_addr, OFF_STAT)) |=> ((stat & ~$past(stat)) == '0)); // R8

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_start && !wr_en) |=> !ctl_b[START_BIT]);                        // R3
endmodule

// File: rtl/sconv_sample_gen.sv
module sconv_sample_gen
  import sconv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int STEP   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [1:0]        res,
  input  logic              left_align,
  output logic [DATA_W-1:0] sample
);
  localparam logic [DATA_W-1:0] ALIGN_KEEP = DATA_W'(32'h0000_FFF0);

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] trunc;

  always_comb begin
    keep   = DATA_W'(res_mask(res));
    trunc  = (acc + DATA_W'(STEP)) & keep;
    sample = left_align ? ((trunc << 1) & ALIGN_KEEP) : trunc;
  end

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (fire) acc <= trunc;
  end

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(acc));                                    // R4

  AST_ACC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    fire |=> ((acc & ~$past(keep)) == '0));                     // R5
endmodule

// File: rtl/synth_conv_regs.sv
module synth_conv_regs
  import sconv_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int N_INJ  = 4,
  parameter int N_SEQ  = 3,
  parameter int STEP   = 7,
  parameter logic [31:0] THR_HI_RST = 32'h0000_0FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [DATA_W-1:0] CTLB_RD_KEEP = DATA_W'((64'd1 << RD_KEEP) - 1);

  logic [DATA_W-1:0] stat, ctl_a, ctl_b, smp_a, smp_b, thr_hi, thr_lo, iseq;
  logic [N_SEQ-1:0][DATA_W-1:0] seq;
  logic [N_INJ-1:0][DATA_W-1:0] ioff, idat;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] rd_val;
  logic              rd_result;
  logic              fire;

  assign rd_result = bus_re && (bus_addr == ADDR_W'(OFF_RESULT));
  assign fire      = rd_result && ctl_b[EN_BIT] && ctl_b[START_BIT];

  sconv_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_INJ(N_INJ), .N_SEQ(N_SEQ),
    .THR_HI_RST(THR_HI_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(bus_we), .wr_addr(bus_addr),
    .wr_data(bus_wdata), .clr_start(fire),
    .stat(stat), .ctl_a(ctl_a), .ctl_b(ctl_b), .smp_a(smp_a), .smp_b(smp_b),
    .thr_hi(thr_hi), .thr_lo(thr_lo), .iseq(iseq), .seq(seq),
    .ioff(ioff), .idat(idat)
  );

  sconv_sample_gen #(.DATA_W(DATA_W), .STEP(STEP)) u_gen (
    .clk(clk), .rst(rst), .fire(fire),
    .res(ctl_a[RES_LSB +: 2]), .left_align(ctl_b[ALIGN_BIT]),
    .sample(sample)
  );

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(OFF_STAT))   rd_val = stat;
    if (bus_addr == ADDR_W'(OFF_CTLA))   rd_val = ctl_a;
    if (bus_addr == ADDR_W'(OFF_CTLB))   rd_val = ctl_b & CTLB_RD_KEEP;
    if (bus_addr == ADDR_W'(OFF_SMPA))   rd_val = smp_a;
    if (bus_addr == ADDR_W'(OFF_SMPB))   rd_val = smp_b;
    if (bus_addr == ADDR_W'(OFF_THRHI))  rd_val = thr_hi;
    if (bus_addr == ADDR_W'(OFF_THRLO))  rd_val = thr_lo;
    if (bus_addr == ADDR_W'(OFF_ISEQ))   rd_val = iseq;
    for (int s = 0; s < N_SEQ; s++)
      if (bus_addr == ADDR_W'(OFF_SEQ0 + 4*s)) rd_val = seq[s];
    for (int n = 0; n < N_INJ; n++) begin
      if (bus_addr == ADDR_W'(OFF_IOFF0 + 4*n)) rd_val = ioff[n];
      if (bus_addr == ADDR_W'(OFF_IDAT0 + 4*n)) rd_val = idat[n] - ioff[n];
    end
    if (rd_result) rd_val = fire ? sample : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_val;
  end

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(bus_re && bus_we));                                                // R2

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));                                     // R2

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_result && !(ctl_b[EN_BIT] && ctl_b[START_BIT])) |=> bus_rdata == '0); // R4

  AST_CTLB_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == ADDR_W'(OFF_CTLB)) |=> bus_rdata[DATA_W-1:RD_KEEP] == '0); // R7

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (fire && !bus_we) |=> !fire);                                        // R12
endmodule

// File: tb/tb_synth_conv_regs.sv
`timescale 1ns/1ps
module tb_synth_conv_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  synth_conv_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata)
  );

  typedef struct packed {
    logic        wr;    // 1: write data, 0: read and compare with exp
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0, 32'h0000_0000, 4'd1},   // R1 status
    '{1'b0, 8'h04, 32'h0, 32'h0000_0000, 4'd1},   // R1 control A
    '{1'b0, 8'h08, 32'h0, 32'h0000_0000, 4'd1},   // R1 control B
    '{1'b0, 8'h24, 32'h0, 32'h0000_0FFF, 4'd1},   // R1 high threshold
    '{1'b0, 8'h3C, 32'h0, 32'h0000_0000, 4'd1},   // R1 injected data
    '{1'b1, 8'h04, 32'h0300_00AB, 32'h0, 4'd10},
    '{1'b0, 8'h04, 32'h0, 32'h0300_00AB, 4'd10},  // R10
    '{1'b1, 8'h0C, 32'h1234_5678, 32'h0, 4'd10},
    '{1'b0, 8'h0C, 32'h0, 32'h1234_5678, 4'd10},
    '{1'b1, 8'h10, 32'hCAFE_F00D, 32'h0, 4'd10},
    '{1'b0, 8'h10, 32'h0, 32'hCAFE_F00D, 4'd10},
    '{1'b1, 8'h24, 32'h0000_0800, 32'h0, 4'd10},
    '{1'b0, 8'h24, 32'h0, 32'h0000_0800, 4'd10},
    '{1'b1, 8'h34, 32'h0A0B_0C0D, 32'h0, 4'd10},
    '{1'b0, 8'h34, 32'h0, 32'h0A0B_0C0D, 4'd10},
    '{1'b1, 8'h38, 32'h00AB_CDEF, 32'h0, 4'd10},
    '{1'b0, 8'h38, 32'h0, 32'h00AB_CDEF, 4'd10},
    '{1'b1, 8'h14, 32'hFFFF_F123, 32'h0, 4'd9},
    '{1'b0, 8'h14, 32'h0, 32'h0000_0123, 4'd9},   // R9 offset narrowed
    '{1'b1, 8'h3C, 32'h0000_0100, 32'h0, 4'd9},
    '{1'b0, 8'h3C, 32'h0, 32'hFFFF_FFDD, 4'd9},   // R9 0x100-0x123 wraps
    '{1'b1, 8'h20, 32'h0000_0001, 32'h0, 4'd9},
    '{1'b0, 8'h48, 32'h0, 32'hFFFF_FFFF, 4'd9},   // R9 0-1
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0, 4'd8},
    '{1'b0, 8'h00, 32'h0, 32'h0000_0000, 4'd8},   // R8 no flag set
    '{1'b1, 8'h50, 32'h0000_DEAD, 32'h0, 4'd11},
    '{1'b0, 8'h50, 32'h0, 32'h0000_0000, 4'd11},  // R11 unmapped
    '{1'b0, 8'h05, 32'h0, 32'h0000_0000, 4'd11},  // R11 unaligned
    '{1'b1, 8'h08, 32'hF000_0002, 32'h0, 4'd7},
    '{1'b0, 8'h08, 32'h0, 32'h0000_0002, 4'd7},   // R7 top nibble hidden
    '{1'b1, 8'h04, 32'h0000_0000, 32'h0, 4'd5}
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] mask_of(input int r);
    case (r)
      0: mask_of = 32'hFFF;
      1: mask_of = 32'h3FF;
      2: mask_of = 32'hFF;
      default: mask_of = 32'h3F;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, acc, exp;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // Table-driven register map checks
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, v);
        check(int'(VEC[i].req), v, VEC[i].exp);
      end
    end

    // R4: result read without enable/start returns 0
    rd(8'h4C, v); check(4, v, 32'h0);
    wr(8'h08, 32'h4000_0000);
    rd(8'h4C, v); check(4, v, 32'h0);
    rd(8'h08, v); check(7, v, 32'h0);            // R7 start bit stored but hidden
    wr(8'h4C, 32'h0000_1234);                    // R11 ignored write to result
    wr(8'h08, 32'h4000_0001);
    rd(8'h4C, v); check(3, v, 32'd7);            // R3 first conversion, acc from 0
    rd(8'h4C, v); check(12, v, 32'h0);           // R12 start already cleared
    rd(8'h08, v); check(3, v, 32'h1);            // R3 start bit cleared

    // R5/R6: each resolution and alignment against a model
    acc = 32'd7;
    for (int r = 3; r >= 0; r--) begin
      wr(8'h04, 32'(r) << 24);
      for (int al = 0; al < 2; al++) begin
        for (int k = 0; k < 12; k++) begin
          wr(8'h08, 32'h4000_0001 | (32'(al) << 11));
          rd(8'h4C, v);
          acc = (acc + 32'd7) & mask_of(r);
          exp = al ? ((acc << 1) & 32'hFFF0) : acc;
          check(al ? 6 : 5, v, exp);
        end
      end
    end

    // R5: long 12-bit run crossing the wrap point
    wr(8'h04, 32'h0);
    for (int k = 0; k < 600; k++) begin
      wr(8'h08, 32'h4000_0001);
      rd(8'h4C, v);
      acc = (acc + 32'd7) & 32'hFFF;
      check(5, v, acc);
    end

    // R12: back-to-back reads, one conversion only
    wr(8'h08, 32'h4000_0001);
    @(negedge clk); bus_addr = 8'h4C; bus_re = 1'b1;
    @(negedge clk); v = bus_rdata;
    @(negedge clk); bus_re = 1'b0; v2 = bus_rdata;
    acc = (acc + 32'd7) & 32'hFFF;
    check(12, v, acc);
    check(12, v2, 32'h0);
    // R2: data holds while idle
    repeat (3) @(negedge clk);
    check(2, bus_rdata, 32'h0);

    // R1: reset mid-run restores defaults and accumulator
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(8'h24, v); check(1, v, 32'h0000_0FFF);
    rd(8'h14, v); check(1, v, 32'h0);
    wr(8'h08, 32'h4000_0001);
    rd(8'h4C, v); check(1, v, 32'd7);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule